// File: doc/BRIEF.md
# Low-Power Mode and Pin-State Controller

This block steers a small microcontroller core between normal running, idle, power-down and an on-circuit emulation state. Software asks for idle or power-down with single-cycle request pulses. From then on the block decides three things: whether the oscillator runs, whether the core clock is gated, and how each of the four ports, ALE and PSEN are driven. The oscillator is modelled as an enable bit plus a counter that declares it stable a fixed number of cycles after a restart.

Idle keeps the oscillator alive and gates only the core. It ends on any enabled interrupt pin event. Power-down stops the oscillator. It ends on a hardware reset, or on an enabled level-sensitive interrupt pin when the wake-enable input is set. That interrupt exit has two phases. A low pin restarts the oscillator. The core is released only once the pin is high again and the stability count has elapsed, and at that point a one-cycle wake event is raised. Emulation mode is latched from the ALE and PSEN sense inputs around the end of reset, and only another reset leaves it.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset the block is in run with osc_en=1, core_clk_en=1, ctl_force=0, ctl_weak=0 and wake_evt=0. Port modes use the code DATA=00, ADDR=01, FLOAT=10, WEAK=11. In run, ports 1 and 3 are DATA, and ports 0 and 2 are ADDR when ext_prog=1 and DATA otherwise.
- R2: An idle request in run gives core_clk_en=0 and osc_en=1 at the next edge, with ctl_force=1 and ALE and PSEN driven 1. If a power-down request arrives in the same cycle, the power-down request wins.
- R3: In idle, an enabled interrupt returns the block to run at the next edge, with core_clk_en=1 and a one-cycle wake_evt pulse. An interrupt counts as enabled when its pin is low while configured level-sensitive (edge bit 0), or when its pin falls from high to low while configured edge-sensitive (edge bit 1). Disabled pins have no effect.
- R4: A power-down request in run gives osc_en=0 and core_clk_en=0 at the next edge, with ctl_force=1 and ALE and PSEN driven 0.
- R5: In power-down, the oscillator restarts (osc_en=1 at the next edge) only when wake_en=1 and an enabled, level-configured pin is low. An edge-configured pin, a disabled pin, or wake_en=0 leaves osc_en at 0.
- R6: After the restart, core_clk_en and wake_evt stay 0 for as long as the waking pin is held low. Leaving power-down needs both the pin high and STABLE_CYC cycles counted. If the pin is released right away, run resumes STABLE_CYC+1 edges after osc_en rises. If it is held longer, run resumes one edge after release. In both cases wake_evt pulses for one cycle together with the rising core_clk_en.
- R7: In idle and power-down, ports 1 and 3 are DATA. Port 0 is FLOAT with ext_prog=1 and DATA otherwise. Port 2 is ADDR only in idle with ext_prog=1, and DATA otherwise.
- R8: Emulation mode is entered when, in the last reset cycle, ale_in=0 and psen_in=1, and ale_in is still 0 in the first cycle after reset. Any other combination leaves the block in run.
- R9: In emulation mode, port 0 is FLOAT, ports 1, 2 and 3 are WEAK, ctl_weak=1, ctl_force=0, osc_en=1 and core_clk_en=0. Idle requests, power-down requests and interrupts there have no effect.
- R10: A reset from any state, including idle, power-down, the oscillator restart and emulation, puts the run outputs of R1 in place at the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| idle_req | input | 1 | Software request pulse for idle |
| pd_req | input | 1 | Software request pulse for power-down |
| wake_en | input | 1 | Allows an interrupt exit from power-down |
| irq_pin_n | input | N_IRQ | External interrupt pins, active low |
| irq_en | input | N_IRQ | Per-pin interrupt enable |
| irq_edge | input | N_IRQ | Per-pin trigger: 1 falling edge, 0 low level |
| ale_in | input | 1 | Sensed ALE pin level |
| psen_in | input | 1 | Sensed PSEN pin level |
| ext_prog | input | 1 | Program memory is external |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Core clock gate enable |
| wake_evt | output | 1 | One-cycle wake indication to the core |
| ale_out | output | 1 | ALE level when forced |
| psen_out | output | 1 | PSEN level when forced |
| ctl_force | output | 1 | This block drives ALE and PSEN |
| ctl_weak | output | 1 | ALE and PSEN weakly pulled high |
| p0_mode | output | 2 | Port 0 drive mode |
| p1_mode | output | 2 | Port 1 drive mode |
| p2_mode | output | 2 | Port 2 drive mode |
| p3_mode | output | 2 | Port 3 drive mode |

## Verification
The bench releases the wake pin at two different points: right after the oscillator restarts, and only after the stability window has passed. A design that exits on the pin alone would wake the core too early. A design that exits on the counter alone would release the core while the pin is still low. Every pin, enable, trigger type and wake-enable combination is swept in both idle and power-down, which catches edge-configured pins that wrongly wake the block from power-down. All eight ALE/PSEN patterns around reset are applied, which catches a design that latches emulation without checking ALE after reset. The run, idle and power-down port maps are checked for both program-memory settings, which catches a swapped port 0 or port 2 mapping.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [2:0] {S_RUN, S_IDLE, S_PD, S_WAKE, S_EMU} pstate_t;

  typedef enum logic [1:0] {
    PM_DATA  = 2'b00,
    PM_ADDR  = 2'b01,
    PM_FLOAT = 2'b10,
    PM_WEAK  = 2'b11
  } pmode_t;

  typedef struct packed {
    logic   osc_en;
    logic   core_en;
    logic   ctl_force;
    logic   ctl_weak;
    logic   ale;
    logic   psen;
    pmode_t p0;
    pmode_t p1;
    pmode_t p2;
    pmode_t p3;
  } pin_cfg_t;
endpackage

// File: rtl/irq_detect.sv
module irq_detect #(
  parameter int N_IRQ = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IRQ-1:0] pin_n,
  input  logic [N_IRQ-1:0] en,
  input  logic [N_IRQ-1:0] edge_sel,
  output logic             any_hit,
  output logic             any_lvl_low
);
  logic [N_IRQ-1:0] pin_q, hit, lvl_low;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) pin_q[i] <= 1'b1;
      else     pin_q[i] <= pin_n[i];
    end
    // edge mode: high on last cycle, low now; level mode: low now
    assign hit[i]     = en[i] & (edge_sel[i] ? (pin_q[i] & ~pin_n[i]) : ~pin_n[i]);
    assign lvl_low[i] = en[i] & ~edge_sel[i] & ~pin_n[i];
  end

  assign any_hit     = |hit;
  assign any_lvl_low = |lvl_low;
endmodule

// File: rtl/osc_stable_cnt.sv
module osc_stable_cnt #(
  parameter int STABLE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic stable
);
  localparam int CNT_W = $clog2(STABLE_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STABLE_CYC);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)     cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign stable = (cnt == LIMIT);
endmodule

// File: rtl/pin_mode_map.sv
module pin_mode_map
  import pwr_pkg::*;
(
  input  pstate_t  st,
  input  logic     ext_prog,
  output pin_cfg_t cfg
);
  always_comb begin
    cfg.osc_en    = 1'b1;
    cfg.core_en   = 1'b0;
    cfg.ctl_force = 1'b1;
    cfg.ctl_weak  = 1'b0;
    cfg.ale       = 1'b1;
    cfg.psen      = 1'b1;
    cfg.p0        = ext_prog ? PM_FLOAT : PM_DATA;
    cfg.p1        = PM_DATA;
    cfg.p2        = PM_DATA;
    cfg.p3        = PM_DATA;
    unique case (st)
      S_RUN: begin
        cfg.core_en   = 1'b1;
        cfg.ctl_force = 1'b0;
        cfg.p0        = ext_prog ? PM_ADDR : PM_DATA;
        cfg.p2        = ext_prog ? PM_ADDR : PM_DATA;
      end
      S_IDLE: begin
        cfg.p2 = ext_prog ? PM_ADDR : PM_DATA;
      end
      S_PD, S_WAKE: begin
        cfg.osc_en = (st == S_WAKE);
        cfg.ale    = 1'b0;
        cfg.psen   = 1'b0;
      end
      S_EMU: begin
        cfg.ctl_force = 1'b0;
        cfg.ctl_weak  = 1'b1;
        cfg.p0        = PM_FLOAT;
        cfg.p1        = PM_WEAK;
        cfg.p2        = PM_WEAK;
        cfg.p3        = PM_WEAK;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_pkg::*;
#(
  parameter int N_IRQ      = 2,
  parameter int STABLE_CYC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idle_req,
  input  logic             pd_req,
  input  logic             wake_en,
  input  logic [N_IRQ-1:0] irq_pin_n,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic [N_IRQ-1:0] irq_edge,
  input  logic             ale_in,
  input  logic             psen_in,
  input  logic             ext_prog,
  output logic             osc_en,
  output logic             core_clk_en,
  output logic             wake_evt,
  output logic             ale_out,
  output logic             psen_out,
  output logic             ctl_force,
  output logic             ctl_weak,
  output logic [1:0]       p0_mode,
  output logic [1:0]       p1_mode,
  output logic [1:0]       p2_mode,
  output logic [1:0]       p3_mode
);
  pstate_t  state, nxt, map_st;
  pin_cfg_t cfg_d, cfg_q;
  logic     any_hit, any_lvl_low, osc_stable;
  logic     rst_d, emu_arm, emu_entry;

  irq_detect #(.N_IRQ(N_IRQ)) irq_i (
    .clk(clk), .rst(rst), .pin_n(irq_pin_n), .en(irq_en), .edge_sel(irq_edge),
    .any_hit(any_hit), .any_lvl_low(any_lvl_low)
  );

  osc_stable_cnt #(.STABLE_CYC(STABLE_CYC)) osc_i (
    .clk(clk), .rst(rst), .run(state == S_WAKE), .stable(osc_stable)
  );

  // emulation is armed in reset and confirmed on the first cycle after it
  assign emu_entry = rst_d & emu_arm & ~ale_in;

  always_comb begin
    nxt = state;
    unique case (state)
      S_RUN:   if (pd_req) nxt = S_PD; else if (idle_req) nxt = S_IDLE;
      S_IDLE:  if (any_hit) nxt = S_RUN;
      S_PD:    if (wake_en && any_lvl_low) nxt = S_WAKE;
      S_WAKE:  if (osc_stable && !any_lvl_low) nxt = S_RUN;
      S_EMU:   nxt = S_EMU;
      default: nxt = S_RUN;
    endcase
    if (emu_entry) nxt = S_EMU;
  end

  assign map_st = rst ? S_RUN : nxt;

  pin_mode_map map_i (.st(map_st), .ext_prog(ext_prog), .cfg(cfg_d));

  always_ff @(posedge clk) begin
    cfg_q <= cfg_d;
    if (rst) begin
      state    <= S_RUN;
      rst_d    <= 1'b1;
      emu_arm  <= ~ale_in & psen_in;
      wake_evt <= 1'b0;
    end else begin
      state    <= nxt;
      rst_d    <= 1'b0;
      emu_arm  <= 1'b0;
      wake_evt <= (nxt == S_RUN) && (state == S_IDLE || state == S_WAKE);
    end
  end

  assign osc_en      = cfg_q.osc_en;
  assign core_clk_en = cfg_q.core_en;
  assign ctl_force   = cfg_q.ctl_force;
  assign ctl_weak    = cfg_q.ctl_weak;
  assign ale_out     = cfg_q.ale;
  assign psen_out    = cfg_q.psen;
  assign p0_mode     = cfg_q.p0;
  assign p1_mode     = cfg_q.p1;
  assign p2_mode     = cfg_q.p2;
  assign p3_mode     = cfg_q.p3;

  // R4 / R6: the core never runs without the oscillator
  a_r4_core_needs_osc: assert property (@(posedge clk) disable iff (rst)
    core_clk_en |-> osc_en);

  // R6: a wake out of the restart state only after the counter completed
  a_r6_wake_after_stable: assert property (@(posedge clk) disable iff (rst)
    (wake_evt && $past(state) == S_WAKE) |-> $past(osc_stable));

  // R6 / R3: wake event lasts one cycle
  a_r3_wake_single: assert property (@(posedge clk) disable iff (rst)
    wake_evt |=> !wake_evt);

  // R5: with wake disabled power-down is held
  a_r5_pd_hold: assert property (@(posedge clk) disable iff (rst)
    (state == S_PD && !wake_en) |=> state == S_PD);

  // R9: emulation only left by reset
  a_r9_emu_sticky: assert property (@(posedge clk) disable iff (rst)
    (state == S_EMU) |=> (state == S_EMU && ctl_weak));

  // R7: forced control pins leave ports 1 and 3 on data
  a_r7_side_ports: assert property (@(posedge clk) disable iff (rst)
    ctl_force |-> (p1_mode == 2'b00 && p3_mode == 2'b00));
endmodule

// File: tb/pwr_state_ctrl_tb_top.sv
module pwr_state_ctrl_tb_top;
  localparam int NP = 2;
  localparam int SC = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, idle_req, pd_req, wake_en, ale_in, psen_in, ext_prog;
  logic [NP-1:0] irq_pin_n, irq_en, irq_edge;
  logic osc_en, core_clk_en, wake_evt, ale_out, psen_out, ctl_force, ctl_weak;
  logic [1:0] p0_mode, p1_mode, p2_mode, p3_mode;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  pwr_state_ctrl #(.N_IRQ(NP), .STABLE_CYC(SC)) dut_i (
    .clk(clk), .rst(rst), .idle_req(idle_req), .pd_req(pd_req), .wake_en(wake_en),
    .irq_pin_n(irq_pin_n), .irq_en(irq_en), .irq_edge(irq_edge),
    .ale_in(ale_in), .psen_in(psen_in), .ext_prog(ext_prog),
    .osc_en(osc_en), .core_clk_en(core_clk_en), .wake_evt(wake_evt),
    .ale_out(ale_out), .psen_out(psen_out), .ctl_force(ctl_force), .ctl_weak(ctl_weak),
    .p0_mode(p0_mode), .p1_mode(p1_mode), .p2_mode(p2_mode), .p3_mode(p3_mode)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic ext);
    rst = 1; idle_req = 0; pd_req = 0; irq_pin_n = '1;
    ale_in = 1; psen_in = 1; ext_prog = ext;
    tick();
    rst = 0;
    tick();
  endtask

  task automatic check_run(input string req, input logic ext);
    check({req, " osc_en"}, osc_en, 1);
    check({req, " core_clk_en"}, core_clk_en, 1);
    check({req, " ctl_force"}, ctl_force, 0);
    check({req, " ctl_weak"}, ctl_weak, 0);
    check({req, " p0"}, p0_mode, ext ? 1 : 0);
    check({req, " p1"}, p1_mode, 0);
    check({req, " p2"}, p2_mode, ext ? 1 : 0);
    check({req, " p3"}, p3_mode, 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst = 1; idle_req = 0; pd_req = 0; wake_en = 0; ale_in = 1; psen_in = 1;
    ext_prog = 0; irq_pin_n = '1; irq_en = '0; irq_edge = '0;

    // R1 reset state for both program-memory settings
    for (int ext = 0; ext < 2; ext++) begin
      do_reset(ext[0]);
      check_run("R1", ext[0]);
      check("R1 wake_evt", wake_evt, 0);
    end

    // R2 / R3 / R7 idle sweep
    for (int ext = 0; ext < 2; ext++)
      for (int p = 0; p < NP; p++)
        for (int ed = 0; ed < 2; ed++)
          for (int en = 0; en < 2; en++) begin
            do_reset(ext[0]);
            irq_en = '0; irq_edge = '0;
            irq_en[p] = en[0]; irq_edge[p] = ed[0];
            idle_req = 1; tick(); idle_req = 0;
            check("R2 core_clk_en", core_clk_en, 0);
            check("R2 osc_en", osc_en, 1);
            check("R2 ctl_force", ctl_force, 1);
            check("R2 ale_out", ale_out, 1);
            check("R2 psen_out", psen_out, 1);
            check("R7 idle p0", p0_mode, ext ? 2 : 0);
            check("R7 idle p2", p2_mode, ext ? 1 : 0);
            check("R7 idle p1", p1_mode, 0);
            check("R7 idle p3", p3_mode, 0);
            tick();
            check("R3 no spurious exit", core_clk_en, 0);
            irq_pin_n[p] = 1'b0; tick();
            check("R3 exit", core_clk_en, en);
            check("R3 wake_evt", wake_evt, en);
            irq_pin_n = '1; tick();
            check("R3 pulse one cycle", wake_evt, 0);
          end

    // R2 priority of power-down
    do_reset(1'b0);
    idle_req = 1; pd_req = 1; tick(); idle_req = 0; pd_req = 0;
    check("R2 pd wins osc_en", osc_en, 0);
    check("R2 pd wins ale_out", ale_out, 0);

    // R4 / R5 / R6 / R7 power-down sweep
    for (int ext = 0; ext < 2; ext++)
      for (int we = 0; we < 2; we++)
        for (int p = 0; p < NP; p++)
          for (int ed = 0; ed < 2; ed++)
            for (int en = 0; en < 2; en++) begin
              int exp_w;
              exp_w = we & en & (1 - ed);
              do_reset(ext[0]);
              wake_en = we[0];
              irq_en = '0; irq_edge = '0;
              irq_en[p] = en[0]; irq_edge[p] = ed[0];
              pd_req = 1; tick(); pd_req = 0;
              check("R4 osc_en", osc_en, 0);
              check("R4 core_clk_en", core_clk_en, 0);
              check("R4 ctl_force", ctl_force, 1);
              check("R4 ale_out", ale_out, 0);
              check("R4 psen_out", psen_out, 0);
              check("R7 pd p0", p0_mode, ext ? 2 : 0);
              check("R7 pd p2", p2_mode, 0);
              check("R7 pd p1", p1_mode, 0);
              irq_pin_n[p] = 1'b0; tick();
              check("R5 osc restart", osc_en, exp_w);
              check("R6 core gated", core_clk_en, 0);
              if (exp_w != 0) begin
                if (ext == 0) begin
                  irq_pin_n = '1;
                  for (int k = 1; k <= SC; k++) begin
                    tick();
                    check("R6 early core gated", core_clk_en, 0);
                    check("R6 early no wake", wake_evt, 0);
                  end
                  tick();
                  check("R6 early exit core", core_clk_en, 1);
                  check("R6 early exit wake", wake_evt, 1);
                end else begin
                  for (int k = 1; k <= 2 * SC; k++) begin
                    tick();
                    check("R6 held core gated", core_clk_en, 0);
                    check("R6 held no wake", wake_evt, 0);
                  end
                  irq_pin_n = '1; tick();
                  check("R6 held exit core", core_clk_en, 1);
                  check("R6 held exit wake", wake_evt, 1);
                end
                tick();
                check("R6 wake one cycle", wake_evt, 0);
              end else begin
                tick(); tick(); tick();
                check("R5 stays off", osc_en, 0);
                irq_pin_n = '1;
              end
            end

    // R10 reset out of the restart state and out of idle
    do_reset(1'b1);
    wake_en = 1; irq_en = 2'b01; irq_edge = '0;
    pd_req = 1; tick(); pd_req = 0;
    irq_pin_n[0] = 1'b0; tick(); tick();
    rst = 1; tick();
    check_run("R10 from restart", 1'b1);
    rst = 0; irq_pin_n = '1; tick();
    idle_req = 1; tick(); idle_req = 0;
    rst = 1; tick();
    check_run("R10 from idle", 1'b1);
    rst = 0; tick();

    // R8 / R9 emulation entry sweep
    ext_prog = 0; wake_en = 1;
    for (int ar = 0; ar < 2; ar++)
      for (int ps = 0; ps < 2; ps++)
        for (int aa = 0; aa < 2; aa++) begin
          int exp_e;
          exp_e = (1 - ar) & ps & (1 - aa);
          irq_en = '0; irq_pin_n = '1;
          rst = 1; ale_in = ar[0]; psen_in = ps[0]; tick();
          rst = 0; ale_in = aa[0]; tick();
          ale_in = 1; psen_in = 1;
          check("R8 ctl_weak", ctl_weak, exp_e);
          check("R8 p0", p0_mode, exp_e ? 2 : 0);
          if (exp_e != 0) begin
            check("R9 p1", p1_mode, 3);
            check("R9 p2", p2_mode, 3);
            check("R9 p3", p3_mode, 3);
            check("R9 osc_en", osc_en, 1);
            check("R9 core_clk_en", core_clk_en, 0);
            check("R9 ctl_force", ctl_force, 0);
            idle_req = 1; pd_req = 1; irq_en = '1; irq_edge = '0; irq_pin_n = '0;
            tick();
            idle_req = 0; pd_req = 0; irq_pin_n = '1; tick();
            check("R9 ignores requests weak", ctl_weak, 1);
            check("R9 ignores requests osc", osc_en, 1);
            check("R9 ignores requests p1", p1_mode, 3);
            check("R9 ignores wake", wake_evt, 0);
            rst = 1; tick();
            check_run("R10 from emulation", 1'b0);
            rst = 0; tick();
          end else begin
            check("R8 run core", core_clk_en, 1);
          end
        end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule